// File: doc/BRIEF.md
# Interlocked Bus Read Link

This block holds both ends of a read transfer that runs over one shared, multiplexed address/data bus with no common timing reference between the two ends. A requester, on the device side, places an address on the bus and later collects a data word. A responder, on the memory side, takes that address, looks it up in a small built-in memory after a configurable delay, and sends the word back on the same wires. Three control lines carry the exchange: a request line, an acknowledge line that either end may raise, and a data-ready line.

Neither end acts on the other's clock. Each end moves forward only after it observes a level change on a line that the other end drives, and every line it observes first passes through a two-stage synchronizer. The transfer forms a closed loop: the address is sent with request, acknowledged, and withdrawn. The word is then sent with data-ready, acknowledged, and withdrawn. The requester reports completion with a one-cycle pulse only after its own acknowledge has been seen released on the line.

Top module: `abr_link`

## Requirements
- R1: After reset the request, acknowledge and data-ready lines are low, neither end drives the bus, the bus reads zero, and busy and done are low.
- R2: Whenever the request line is high, the requester alone drives the bus, and the bus carries the start address, zero-extended.
- R3: The data-ready line is never high while the request line is high. The responder raises data-ready only after it has observed the request withdrawn.
- R4: The word returned for address a is (a*29 + 90) modulo 2^DW. This holds for every address of the memory.
- R5: At most one end enables its bus driver in any cycle.
- R6: Done is high for exactly one cycle. When done is high, the acknowledge line is low and data_o holds the returned word.
- R7: For latency settings of 3 or more, raising the latency parameter by N cycles lengthens the time from start to done by exactly N cycles.
- R8: A start pulse that arrives while busy is high is ignored. No second transfer and no second done result from it, and the first transfer returns its own word.
- R9: The time from start to done is the same for every address.
- R10: While data-ready is high, the responder alone drives the bus, and the bus carries the word for the latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation clock shared by both ends |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a read when the requester is idle |
| addr_i | input | AW | Address for the read, taken with start_i |
| busy_o | output | 1 | Requester is in a transfer |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | DW | Word captured by the requester |
| req_line_o | output | 1 | Request line |
| ack_line_o | output | 1 | Acknowledge line (OR of both ends) |
| rdy_line_o | output | 1 | Data-ready line |
| bus_o | output | BW | Shared bus value |
| req_drv_o | output | 1 | Requester bus drive enable |
| rsp_drv_o | output | 1 | Responder bus drive enable |

## Verification
Every address of the memory is read in turn, so each stored word is separated from its neighbours by the arithmetic pattern. Any wrong latch of the address from the bus shows up as a wrong word. The same sweep runs on two instances that differ only in latency. Their start-to-done counts must differ by the latency gap, and each count must stay constant across addresses. This separates a delay that is properly parameterised from one that depends on the data. A second start pulse placed inside a running transfer, with a different address, shows whether the requester ignores it. On every cycle a monitor compares the bus against the address or the word, according to the line that is raised, and checks for overlapping drivers.

// File: rtl/abr_pkg.sv
package abr_pkg;

    typedef enum logic [2:0] {
        Q_IDLE, Q_ADDR, Q_ACK_LO, Q_WAIT_RDY, Q_ACK, Q_RELEASE
    } qst_e;

    typedef enum logic [2:0] {
        P_IDLE, P_ACKHI, P_FETCH, P_DRIVE, P_FINISH
    } pst_e;

    // Pattern held by the built-in memory at each location.
    function automatic logic [31:0] word_at(input int unsigned a);
        return 32'(a * 29 + 90);
    endfunction

endpackage

// File: rtl/abr_sync2.sv
module abr_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= in_i;
            s2_q <= s1_q;
        end
    end

    assign out_o = s2_q;
endmodule

// File: rtl/abr_requester.sv
module abr_requester
    import abr_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic          ack_s_i,
    input  logic          rdy_s_i,
    input  logic [BW-1:0] bus_i,
    output logic          req_o,
    output logic          ack_o,
    output logic          drv_o,
    output logic [BW-1:0] bus_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        qst_e          st;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          req;
        logic          ack;
        logic          done;
    } rq_t;

    rq_t q_q, q_d;

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        unique case (q_q.st)
            Q_IDLE: if (start_i) begin
                q_d.addr = addr_i;
                q_d.req  = 1'b1;
                q_d.st   = Q_ADDR;
            end
            Q_ADDR: if (ack_s_i) begin
                q_d.req = 1'b0;
                q_d.st  = Q_ACK_LO;
            end
            Q_ACK_LO: if (!ack_s_i) q_d.st = Q_WAIT_RDY;
            Q_WAIT_RDY: if (rdy_s_i) begin
                q_d.data = bus_i[DW-1:0];
                q_d.ack  = 1'b1;
                q_d.st   = Q_ACK;
            end
            Q_ACK: if (!rdy_s_i) begin
                q_d.ack = 1'b0;
                q_d.st  = Q_RELEASE;
            end
            Q_RELEASE: if (!ack_s_i) begin
                q_d.done = 1'b1;
                q_d.st   = Q_IDLE;
            end
            default: q_d.st = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{st: Q_IDLE, addr: '0, data: '0, req: 1'b0, ack: 1'b0, done: 1'b0};
        else        q_q <= q_d;
    end

    assign req_o  = q_q.req;
    assign ack_o  = q_q.ack;
    assign drv_o  = (q_q.st == Q_ADDR);
    assign bus_o  = BW'(q_q.addr);
    assign busy_o = (q_q.st != Q_IDLE);
    assign done_o = q_q.done;
    assign data_o = q_q.data;

    // R8: a start seen while a transfer runs leaves the held address alone
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(q_q.addr));

    // R6: completion pulse never lasts two cycles
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/abr_responder.sv
module abr_responder
    import abr_pkg::*;
#(
    parameter int AW  = 4,
    parameter int DW  = 8,
    parameter int BW  = 8,
    parameter int LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_s_i,
    input  logic          ack_s_i,
    input  logic [BW-1:0] bus_i,
    output logic          ack_o,
    output logic          rdy_o,
    output logic          drv_o,
    output logic [BW-1:0] bus_o
);
    localparam int DEPTH = 1 << AW;
    localparam int LATC  = (LAT < 1) ? 1 : LAT;
    localparam int CW    = $clog2(LATC + 1);

    logic [DW-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = DW'(word_at(g));
    end

    typedef struct packed {
        pst_e          st;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic [DW-1:0] word;
        logic          ack;
        logic          rdy;
    } rs_t;

    rs_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        unique case (p_q.st)
            P_IDLE: if (req_s_i) begin
                p_d.addr = bus_i[AW-1:0];
                p_d.ack  = 1'b1;
                p_d.st   = P_ACKHI;
            end
            P_ACKHI: if (!req_s_i) begin
                p_d.ack = 1'b0;
                p_d.cnt = CW'(LATC);
                p_d.st  = P_FETCH;
            end
            P_FETCH: begin
                if (p_q.cnt > CW'(1)) begin
                    p_d.cnt = p_q.cnt - CW'(1);
                end else if (!ack_s_i) begin
                    p_d.word = rom[p_q.addr];
                    p_d.rdy  = 1'b1;
                    p_d.st   = P_DRIVE;
                end
            end
            P_DRIVE: if (ack_s_i) begin
                p_d.rdy = 1'b0;
                p_d.st  = P_FINISH;
            end
            P_FINISH: if (!ack_s_i) p_d.st = P_IDLE;
            default: p_d.st = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{st: P_IDLE, addr: '0, cnt: '0, word: '0, ack: 1'b0, rdy: 1'b0};
        else        p_q <= p_d;
    end

    assign ack_o = p_q.ack;
    assign rdy_o = p_q.rdy;
    assign drv_o = (p_q.st == P_DRIVE);
    assign bus_o = BW'(p_q.word);

    // R3: data is offered only while the synchronized request is low
    a_r3_offer_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> !$past(req_s_i));
endmodule

// File: rtl/abr_link.sv
module abr_link #(
    parameter int AW  = 4,
    parameter int DW  = 8,
    parameter int LAT = 4,
    localparam int BW = (AW > DW) ? AW : DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] data_o,
    output logic          req_line_o,
    output logic          ack_line_o,
    output logic          rdy_line_o,
    output logic [BW-1:0] bus_o,
    output logic          req_drv_o,
    output logic          rsp_drv_o
);
    logic          rq_req, rq_ack, rq_drv;
    logic          rs_ack, rs_rdy, rs_drv;
    logic [BW-1:0] rq_bus, rs_bus, bus;
    logic          ack_line;
    logic [1:0]    rq_sync, rs_sync;

    assign ack_line = rq_ack | rs_ack;
    assign bus      = rq_drv ? rq_bus : (rs_drv ? rs_bus : '0);

    // requester observes acknowledge (bit 1) and data-ready (bit 0)
    abr_sync2 #(.W(2)) rq_sync_i (
        .clk(clk), .rst_n(rst_n), .in_i({ack_line, rs_rdy}), .out_o(rq_sync)
    );
    // responder observes request (bit 1) and acknowledge (bit 0)
    abr_sync2 #(.W(2)) rs_sync_i (
        .clk(clk), .rst_n(rst_n), .in_i({rq_req, ack_line}), .out_o(rs_sync)
    );

    abr_requester #(.AW(AW), .DW(DW), .BW(BW)) rq_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .ack_s_i(rq_sync[1]), .rdy_s_i(rq_sync[0]), .bus_i(bus),
        .req_o(rq_req), .ack_o(rq_ack), .drv_o(rq_drv), .bus_o(rq_bus),
        .busy_o(busy_o), .done_o(done_o), .data_o(data_o)
    );

    abr_responder #(.AW(AW), .DW(DW), .BW(BW), .LAT(LAT)) rs_i (
        .clk(clk), .rst_n(rst_n), .req_s_i(rs_sync[1]), .ack_s_i(rs_sync[0]),
        .bus_i(bus), .ack_o(rs_ack), .rdy_o(rs_rdy), .drv_o(rs_drv), .bus_o(rs_bus)
    );

    assign req_line_o = rq_req;
    assign ack_line_o = ack_line;
    assign rdy_line_o = rs_rdy;
    assign bus_o      = bus;
    assign req_drv_o  = rq_drv;
    assign rsp_drv_o  = rs_drv;

    // R5: never two drivers on the shared bus
    a_r5_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(rq_drv && rs_drv));

    // R3: request and data-ready are never up together
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(rq_req && rs_rdy));

    // R6: completion is reported only once the acknowledge line is released
    a_r6_done_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !ack_line);

    // R10: data-ready always comes with the responder on the bus
    a_r10_rdy_driven: assert property (@(posedge clk) disable iff (!rst_n)
        rs_rdy |-> rs_drv);

    // R2: request always comes with the requester on the bus
    a_r2_req_driven: assert property (@(posedge clk) disable iff (!rst_n)
        rq_req |-> rq_drv);
endmodule

// File: tb/abr_link_tb.sv
`timescale 1ns/1ps
module abr_link_tb_top;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int BW = 8;
    localparam int LAT_F = 4;
    localparam int LAT_S = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] addr = '0;

    logic busy_f, done_f, req_f, ack_f, rdy_f, rqd_f, rsd_f;
    logic [DW-1:0] data_f;
    logic [BW-1:0] bus_f;
    logic busy_s, done_s, req_s, ack_s, rdy_s, rqd_s, rsd_s;
    logic [DW-1:0] data_s;
    logic [BW-1:0] bus_s;

    int checks = 0;
    int fails = 0;
    int mon_bad = 0;
    int cyc = 0;
    bit finished = 0;
    logic [AW-1:0] cur_addr = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    abr_link #(.AW(AW), .DW(DW), .LAT(LAT_F)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
        .busy_o(busy_f), .done_o(done_f), .data_o(data_f),
        .req_line_o(req_f), .ack_line_o(ack_f), .rdy_line_o(rdy_f),
        .bus_o(bus_f), .req_drv_o(rqd_f), .rsp_drv_o(rsd_f)
    );

    abr_link #(.AW(AW), .DW(DW), .LAT(LAT_S)) dut_slow_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
        .busy_o(busy_s), .done_o(done_s), .data_o(data_s),
        .req_line_o(req_s), .ack_line_o(ack_s), .rdy_line_o(rdy_s),
        .bus_o(bus_s), .req_drv_o(rqd_s), .rsp_drv_o(rsd_s)
    );

    function automatic logic [DW-1:0] exp_word(input int a);
        return DW'((a * 29 + 90) % 256);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // bus discipline monitor on the fast instance (R2, R3, R5, R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rqd_f && rsd_f) mon_bad++;
            if (req_f && rdy_f) mon_bad++;
            if (req_f && (!rqd_f || bus_f != BW'(cur_addr))) mon_bad++;
            if (rdy_f && (!rsd_f || bus_f != BW'(exp_word(int'(cur_addr))))) mon_bad++;
        end
    end

    task automatic do_txn(input logic [AW-1:0] a, output int lf, output int ls,
                          output logic [DW-1:0] df, output logic [DW-1:0] ds,
                          output bit pulse_bad);
        @(negedge clk);
        start = 1'b1;
        addr = a;
        cur_addr = a;
        @(negedge clk);
        start = 1'b0;
        lf = -1; ls = -1; df = '0; ds = '0; pulse_bad = 0;
        for (int c = 1; c < 500 && (lf < 0 || ls < 0); c++) begin
            if (lf > 0 && c == lf + 1 && done_f) pulse_bad = 1;
            if (lf > 0 && c == lf + 1 && data_f != df) pulse_bad = 1;
            if (done_f && lf < 0) begin lf = c; df = data_f; end
            if (done_s && ls < 0) begin ls = c; ds = data_s; end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int lf, ls, ref_lat, nd, mb;
        logic [DW-1:0] df, ds;
        bit pb;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(!req_f && !ack_f && !rdy_f, "R1 lines low", {req_f, ack_f, rdy_f}, 0);
        check(!rqd_f && !rsd_f && bus_f == '0, "R1 no driver", int'(bus_f), 0);
        check(!busy_f && !done_f, "R1 busy/done low", {busy_f, done_f}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        ref_lat = -1;
        for (int a = 0; a < (1 << AW); a++) begin
            mb = mon_bad;
            do_txn(AW'(a), lf, ls, df, ds, pb);
            // R4: word pattern on both instances
            check(lf > 0 && df == exp_word(a), "R4 fast word", int'(df), int'(exp_word(a)));
            check(ls > 0 && ds == exp_word(a), "R4 slow word", int'(ds), int'(exp_word(a)));
            // R6: single-cycle done, data held
            check(!pb, "R6 done pulse", int'(pb), 0);
            // R7: latency gap equals parameter gap
            check(ls - lf == LAT_S - LAT_F, "R7 latency gap", ls - lf, LAT_S - LAT_F);
            // R9: same latency for every address
            if (ref_lat < 0) ref_lat = lf;
            check(lf == ref_lat, "R9 constant latency", lf, ref_lat);
            // R2 R3 R5 R10: bus discipline over the whole transfer
            check(mon_bad == mb, "R2/R3/R5/R10 bus discipline", mon_bad - mb, 0);
            repeat (3) @(negedge clk);
        end

        // R8: a second start during a transfer is ignored
        @(negedge clk);
        start = 1'b1; addr = 4'd3; cur_addr = 4'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check(busy_f, "R8 busy during transfer", int'(busy_f), 1);
        start = 1'b1; addr = 4'd12;
        @(negedge clk);
        start = 1'b0;
        nd = 0; df = '0;
        for (int c = 0; c < 200; c++) begin
            if (done_f) begin nd++; df = data_f; end
            @(negedge clk);
        end
        check(nd == 1, "R8 single done", nd, 1);
        check(df == exp_word(3), "R8 first word kept", int'(df), int'(exp_word(3)));
        check(!busy_f && !req_f, "R8 idle afterwards", {busy_f, req_f}, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule